// File: doc/BRIEF.md
# I2C Master Status and Bus Monitor

This block keeps the status word of an I2C master and watches the bus for START and STOP conditions. It takes the glitch-filtered SCL and SDA lines, or, when internal loopback is selected, the levels this master is driving on those lines. It registers them and decodes the bus conditions from the registered copies. It also receives single-cycle event pulses from the master engine and holds them in sticky flags until software reads the status word.

A read is signalled by a one-cycle `rd_stat` pulse. The status word seen in that cycle is the value returned to software, and every sticky flag clears at the following clock edge. If a new event arrives in the same cycle as the read, its flag stays set, so no event is lost. Four of the flags can raise the interrupt line, each through its own enable input.

The flag for a STOP seen on the bus is kept apart from the flag for a STOP that this master drove itself. The bus-STOP flag is only recorded while the master is enabled. The transmit-underflow flag is only recorded while its interrupt enable is 1.

Top module: `i2cm_status_mon`

## Requirements
- R1: After reset the status word is 0x6000. Bit 15 and bits 4 to 0 always read 0.
- R2: Bit 14 shows the selected SCL level and bit 13 the selected SDA level, one clock after the input changes.
- R3: With `lpbk_en`=1 the selected levels are `scl_out`/`sda_out`. With `lpbk_en`=0 they are `scl_in`/`sda_in`.
- R4: Bit 10 (line busy) goes to 1 two clocks after SDA falls while SCL is high (START). It goes to 0 two clocks after SDA rises while SCL is high (STOP). A read does not clear it.
- R5: Bit 8 (transaction complete) sets on a bus STOP only while `mst_en`=1, and clears on read.
- R6: Bit 11 (own STOP) sets only on `ev_own_stop`, never on a bus STOP alone, and clears on read.
- R7: Bit 12 (transmit underflow) sets on `ev_tx_dry` only while `ie_tx`=1, and clears on read.
- R8: Bit 9 (receive overflow) sets on `ev_rx_full_wr` and clears on read.
- R9: Bit 7 (data NACK) and bit 5 (arbitration lost) set on their event pulses, hold until a read, and clear on read.
- R10: Bit 6 (busy) follows `eng_busy` one clock later.
- R11: An event in the same cycle as `rd_stat` leaves its flag set after the read.
- R12: `irq` is the OR of: bit 8 AND `ie_cmp`, bit 12 AND `ie_tx`, bit 7 AND `ie_nack`, bit 5 AND `ie_alost`. Bits 11 and 9 never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Filtered SCL from the pad |
| sda_in | input | 1 | Filtered SDA from the pad |
| scl_out | input | 1 | SCL level this master drives |
| sda_out | input | 1 | SDA level this master drives |
| lpbk_en | input | 1 | Select the driven levels instead of the pad levels |
| mst_en | input | 1 | Master enabled |
| ev_own_stop | input | 1 | Pulse: this master drove STOP |
| ev_tx_dry | input | 1 | Pulse: transaction ended on empty transmit FIFO |
| ev_rx_full_wr | input | 1 | Pulse: write into a full receive FIFO |
| ev_data_nack | input | 1 | Pulse: no ACK after a data byte |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| eng_busy | input | 1 | Master engine servicing a transaction |
| ie_cmp | input | 1 | Interrupt enable, transaction complete |
| ie_tx | input | 1 | Interrupt enable, transmit; also gates underflow capture |
| ie_nack | input | 1 | Interrupt enable, data NACK |
| ie_alost | input | 1 | Interrupt enable, arbitration lost |
| rd_stat | input | 1 | Status read strobe |
| stat_word | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag-setting event that lands in the same cycle as the read strobe. The bench drives the event pulse and `rd_stat` in the same cycle, then checks that the flag is still set. The bus-condition cases need SCL and SDA edges in a set order. The bench builds each START and STOP edge by edge, both from the pads and through loopback, and sweeps every pad and driven level combination with loopback on and off. The interrupt line is checked against all sixteen enable patterns, first with every flag set and then after the flags have been cleared.

// File: rtl/i2cm_stat_pkg.sv
package i2cm_stat_pkg;
  localparam int STAT_W = 16;

  // Status word bit positions (software decodes these)
  localparam int B_SCL    = 14;
  localparam int B_SDA    = 13;
  localparam int B_TXUF   = 12;
  localparam int B_MSTOP  = 11;
  localparam int B_LBUSY  = 10;
  localparam int B_RXOF   = 9;
  localparam int B_TCOMP  = 8;
  localparam int B_NACK   = 7;
  localparam int B_BUSY   = 6;
  localparam int B_ALOST  = 5;

  // Sticky flag bank indices
  localparam int F_TXUF  = 0;
  localparam int F_MSTOP = 1;
  localparam int F_RXOF  = 2;
  localparam int F_TCOMP = 3;
  localparam int F_NACK  = 4;
  localparam int F_ALOST = 5;
  localparam int NFLAG   = 6;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;

  localparam line_pair_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};
endpackage

// File: rtl/i2cm_line_sel.sv
module i2cm_line_sel
  import i2cm_stat_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lpbk_en,
  input  line_pair_t pad,
  input  line_pair_t drv,
  output line_pair_t cur,
  output line_pair_t prev
);
  localparam int LAST = STAGES - 1;

  line_pair_t pipe [STAGES];
  line_pair_t sel;

  always_comb sel = lpbk_en ? drv : pad;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= LINES_IDLE;
    else     pipe[0] <= sel;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= LINES_IDLE;
      else     pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= LINES_IDLE;
    else     prev <= pipe[LAST];
  end

  assign cur = pipe[LAST];
endmodule

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det
  import i2cm_stat_pkg::*;
(
  input  line_pair_t cur,
  input  line_pair_t prev,
  output logic       start_det,
  output logic       stop_det
);
  logic scl_high;

  always_comb begin
    scl_high  = cur.scl & prev.scl;
    start_det = scl_high & prev.sda & ~cur.sda;
    stop_det  = scl_high & ~prev.sda & cur.sda;
  end
endmodule

// File: rtl/i2cm_flag_bank.sv
module i2cm_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         rd,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (rd)     q[i] <= 1'b0;
    end

    // R11: a set in the read cycle survives the read
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
    // R9: a flag holds until a read
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !rd) |=> q[i]);
    a_r9_clear_on_read: assert property (@(posedge clk) disable iff (rst)
      (rd && !set[i]) |=> !q[i]);
  end
endmodule

// File: rtl/i2cm_status_mon.sv
module i2cm_status_mon
  import i2cm_stat_pkg::*;
#(
  parameter int LINE_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              scl_out,
  input  logic              sda_out,
  input  logic              lpbk_en,
  input  logic              mst_en,
  input  logic              ev_own_stop,
  input  logic              ev_tx_dry,
  input  logic              ev_rx_full_wr,
  input  logic              ev_data_nack,
  input  logic              ev_arb_lost,
  input  logic              eng_busy,
  input  logic              ie_cmp,
  input  logic              ie_tx,
  input  logic              ie_nack,
  input  logic              ie_alost,
  input  logic              rd_stat,
  output logic [STAT_W-1:0] stat_word,
  output logic              irq
);
  line_pair_t        pad_l, drv_l, cur_l, prev_l;
  logic              start_det, stop_det;
  logic [NFLAG-1:0]  fl_set, fl_q, fl_ie;
  logic              line_busy_q, busy_q;

  assign pad_l = '{scl: scl_in,  sda: sda_in};
  assign drv_l = '{scl: scl_out, sda: sda_out};

  i2cm_line_sel #(.STAGES(LINE_STAGES)) u_lines (
    .clk(clk), .rst(rst), .lpbk_en(lpbk_en),
    .pad(pad_l), .drv(drv_l), .cur(cur_l), .prev(prev_l)
  );

  i2cm_cond_det u_cond (
    .cur(cur_l), .prev(prev_l),
    .start_det(start_det), .stop_det(stop_det)
  );

  always_comb begin
    fl_set          = '0;
    fl_set[F_TXUF]  = ev_tx_dry & ie_tx;
    fl_set[F_MSTOP] = ev_own_stop;
    fl_set[F_RXOF]  = ev_rx_full_wr;
    fl_set[F_TCOMP] = stop_det & mst_en;
    fl_set[F_NACK]  = ev_data_nack;
    fl_set[F_ALOST] = ev_arb_lost;
  end

  i2cm_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(fl_set), .rd(rd_stat), .q(fl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_busy_q <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      busy_q <= eng_busy;
      if (start_det)     line_busy_q <= 1'b1;
      else if (stop_det) line_busy_q <= 1'b0;
    end
  end

  always_comb begin
    stat_word          = '0;
    stat_word[B_SCL]   = cur_l.scl;
    stat_word[B_SDA]   = cur_l.sda;
    stat_word[B_TXUF]  = fl_q[F_TXUF];
    stat_word[B_MSTOP] = fl_q[F_MSTOP];
    stat_word[B_LBUSY] = line_busy_q;
    stat_word[B_RXOF]  = fl_q[F_RXOF];
    stat_word[B_TCOMP] = fl_q[F_TCOMP];
    stat_word[B_NACK]  = fl_q[F_NACK];
    stat_word[B_BUSY]  = busy_q;
    stat_word[B_ALOST] = fl_q[F_ALOST];
  end

  always_comb begin
    fl_ie          = '0;
    fl_ie[F_TXUF]  = ie_tx;
    fl_ie[F_TCOMP] = ie_cmp;
    fl_ie[F_NACK]  = ie_nack;
    fl_ie[F_ALOST] = ie_alost;
    irq            = |(fl_q & fl_ie);
  end

  // R4: a START marks the line busy at the next edge
  a_r4_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    start_det |=> stat_word[B_LBUSY]);
  a_r4_idle_on_stop: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !stat_word[B_LBUSY]);
  // R5: completion only captured while enabled
  a_r5_tcomp_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_word[B_TCOMP]) |-> $past(mst_en));
  // R6: own-stop flag only from the engine pulse
  a_r6_own_stop_src: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_word[B_MSTOP]) |-> $past(ev_own_stop));
  // R7: underflow only captured with its enable
  a_r7_txuf_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_word[B_TXUF]) |-> $past(ev_tx_dry && ie_tx));
  // R10: busy bit follows the engine one clock later
  a_r10_busy_follow: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> stat_word[B_BUSY]);
endmodule

// File: tb/tb_i2cm_status_mon.sv
module tb_i2cm_status_mon;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1, sda_in = 1, scl_out = 1, sda_out = 1, lpbk_en = 0, mst_en = 0;
  logic ev_own_stop = 0, ev_tx_dry = 0, ev_rx_full_wr = 0, ev_data_nack = 0;
  logic ev_arb_lost = 0, eng_busy = 0;
  logic ie_cmp = 0, ie_tx = 0, ie_nack = 0, ie_alost = 0, rd_stat = 0;
  logic [15:0] stat_word;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2cm_status_mon dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_stat = 1; cyc(1); rd_stat = 0;
  endtask

  task automatic bus_start();
    scl_in = 1; sda_in = 1; cyc(2);
    sda_in = 0; cyc(2);
  endtask

  task automatic bus_stop();
    scl_in = 1; sda_in = 0; cyc(2);
    sda_in = 1; cyc(2);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R1 reset word", stat_word, 16'h6000);

    // R2/R3: level reflection sweep with loopback off and on
    for (int v = 0; v < 32; v++) begin
      lpbk_en = v[4]; scl_in = v[3]; sda_in = v[2]; scl_out = v[1]; sda_out = v[0];
      cyc(1);
      chk(v[4] ? "R3 loopback levels" : "R2 pad levels", {14'd0, stat_word[14:13]},
          {14'd0, (v[4] ? v[1:0] : v[3:2])});
      chk("R1 reserved bits zero", {11'd0, stat_word[15], stat_word[4:0]}, 16'd0);
    end
    lpbk_en = 0; scl_out = 1; sda_out = 1;
    bus_stop(); do_read();

    // R4: START then STOP
    mst_en = 0;
    bus_start();
    chk("R4 busy after start", {15'd0, stat_word[10]}, 16'd1);
    do_read();
    chk("R4 read leaves busy", {15'd0, stat_word[10]}, 16'd1);
    bus_stop();
    chk("R4 idle after stop", {15'd0, stat_word[10]}, 16'd0);
    chk("R5 no tcomp when disabled", {15'd0, stat_word[8]}, 16'd0);

    // R5/R6: enabled bus stop
    mst_en = 1;
    bus_start(); bus_stop();
    chk("R5 tcomp on stop", {15'd0, stat_word[8]}, 16'd1);
    chk("R6 bus stop not own", {15'd0, stat_word[11]}, 16'd0);
    do_read();
    chk("R5 tcomp cleared", {15'd0, stat_word[8]}, 16'd0);

    // R3: START/STOP through loopback with pads held idle
    lpbk_en = 1; scl_out = 1; sda_out = 0; cyc(2);
    chk("R3 loopback start", {15'd0, stat_word[10]}, 16'd1);
    sda_out = 1; cyc(2);
    chk("R3 loopback stop", {15'd0, stat_word[10]}, 16'd0);
    lpbk_en = 0; do_read(); mst_en = 0;

    ev_own_stop = 1; cyc(1); ev_own_stop = 0;
    chk("R6 own stop", {15'd0, stat_word[11]}, 16'd1);
    chk("R12 own stop no irq", {15'd0, irq}, 16'd0);
    do_read();
    chk("R6 own stop cleared", {15'd0, stat_word[11]}, 16'd0);

    // R7
    ie_tx = 0; ev_tx_dry = 1; cyc(1); ev_tx_dry = 0;
    chk("R7 underflow gated", {15'd0, stat_word[12]}, 16'd0);
    ie_tx = 1; ev_tx_dry = 1; cyc(1); ev_tx_dry = 0;
    chk("R7 underflow set", {15'd0, stat_word[12]}, 16'd1);
    ie_tx = 0; do_read();
    chk("R7 underflow cleared", {15'd0, stat_word[12]}, 16'd0);

    // R8
    ev_rx_full_wr = 1; cyc(1); ev_rx_full_wr = 0; cyc(3);
    chk("R8 overflow held", {15'd0, stat_word[9]}, 16'd1);
    chk("R12 overflow no irq", {15'd0, irq}, 16'd0);
    do_read();
    chk("R8 overflow cleared", {15'd0, stat_word[9]}, 16'd0);

    // R9
    ev_data_nack = 1; cyc(1); ev_data_nack = 0;
    ev_arb_lost = 1; cyc(1); ev_arb_lost = 0; cyc(4);
    chk("R9 nack and alost held", {14'd0, stat_word[7], stat_word[5]}, 16'd3);
    do_read();
    chk("R9 cleared on read", {14'd0, stat_word[7], stat_word[5]}, 16'd0);

    // R10
    eng_busy = 1; #1;
    chk("R10 busy not yet", {15'd0, stat_word[6]}, 16'd0);
    cyc(1);
    chk("R10 busy follows", {15'd0, stat_word[6]}, 16'd1);
    eng_busy = 0; cyc(1);
    chk("R10 busy drops", {15'd0, stat_word[6]}, 16'd0);

    // R11: event coincident with read
    ev_data_nack = 1; cyc(1); ev_data_nack = 0;
    ev_arb_lost = 1; rd_stat = 1; cyc(1); ev_arb_lost = 0; rd_stat = 0;
    chk("R11 alost survives read", {15'd0, stat_word[5]}, 16'd1);
    chk("R11 nack cleared by same read", {15'd0, stat_word[7]}, 16'd0);
    do_read();

    // R12: enable sweep with all four interrupting flags set
    ie_tx = 1; ev_tx_dry = 1; ev_data_nack = 1; ev_arb_lost = 1; cyc(1);
    ev_tx_dry = 0; ev_data_nack = 0; ev_arb_lost = 0;
    mst_en = 1; bus_start(); bus_stop(); mst_en = 0;
    for (int e = 0; e < 16; e++) begin
      {ie_cmp, ie_tx, ie_nack, ie_alost} = e[3:0]; #1;
      chk("R12 irq with flags set", {15'd0, irq}, {15'd0, (e != 0)});
    end
    do_read();
    for (int e = 0; e < 16; e++) begin
      {ie_cmp, ie_tx, ie_nack, ie_alost} = e[3:0]; #1;
      chk("R12 irq with flags clear", {15'd0, irq}, 16'd0);
    end
    // R12: single flag, single enable
    {ie_cmp, ie_tx, ie_nack, ie_alost} = 4'b0; #1;
    ev_data_nack = 1; cyc(1); ev_data_nack = 0;
    ie_alost = 1; #1;
    chk("R12 wrong enable", {15'd0, irq}, 16'd0);
    ie_nack = 1; #1;
    chk("R12 matching enable", {15'd0, irq}, 16'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule